// File: doc/BRIEF.md
# Retriggerable Clearable One-Shot Pulse Timer

This block is a clocked one-shot. A qualified edge on either of two trigger inputs raises the output `q_o` for a programmed number of clock cycles. A cycle counter measures the pulse length. The `qn_o` output always carries the inverse of `q_o`.

The two triggers have opposite polarity, and each is gated by the level of the other:

- `trig_fall_i` fires on a falling edge, but only while `trig_rise_i` is high.
- `trig_rise_i` fires on a rising edge, but only while `trig_fall_i` is low.

Both trigger inputs and the active-low clear `clr_n_i` pass through a two-stage synchroniser. Edges are found by comparing each synchronised level with its value one cycle earlier.

By default a fresh trigger during a pulse reloads the counter, so closely spaced triggers stretch the pulse for as long as they keep arriving. Setting `lock_i` makes the pulse non-retriggerable: triggers during a pulse are ignored. Pulling the clear low ends a pulse and blocks new ones, and it takes priority over a trigger seen in the same cycle. Typical uses are missing-pulse detection, stretching short events and fixed-delay generation.

Top module: `oneshot_timer`

## Requirements
- R1: A falling edge on `trig_fall_i` starts a pulse only if `trig_rise_i` is 1 at that time. With `trig_rise_i` at 0 the edge has no effect.
- R2: A rising edge on `trig_rise_i` starts a pulse only if `trig_fall_i` is 0 at that time. With `trig_fall_i` at 1 the edge has no effect.
- R3: `q_o` is 0 during and after reset and while idle, and 1 during a pulse. `qn_o` equals the inverse of `q_o` in every cycle.
- R4: With `lock_i` = 0, an accepted trigger during a pulse restarts the full interval and `q_o` stays 1 without a gap. N triggers spaced G cycles apart (G < L) give one pulse of (N-1)*G + L cycles.
- R5: With `lock_i` = 1, triggers arriving during a pulse are ignored, and the pulse lasts exactly its original L cycles.
- R6: Driving `clr_n_i` to 0 ends an active pulse. `q_o` is 0 from the third rising clock edge after the change, and still 1 just before that edge.
- R7: While `clr_n_i` is held at 0, trigger activity produces no pulse and no single-cycle spike on `q_o`.
- R8: If `clr_n_i` falls in the same cycle as a qualified trigger edge, no pulse starts.
- R9: If `clr_n_i` rises in the same cycle as a qualified trigger edge, the trigger is honoured and a full pulse follows.
- R10: `len_i` (16 bits) gives the pulse length L in cycles, and the value 0 gives a 1-cycle pulse. `len_i` is sampled only when a trigger is accepted, so changing it mid-pulse does not alter that pulse.
- R11: `q_o` rises on the third rising clock edge after a trigger input changes. A level held steady never triggers a second time.
- R12: Once a pulse ends, the block is idle again at once, and a new qualified edge starts a new pulse with the same latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| trig_fall_i | input | 1 | Trigger that fires on a falling edge; qualifies `trig_rise_i` |
| trig_rise_i | input | 1 | Trigger that fires on a rising edge; qualifies `trig_fall_i` |
| clr_n_i | input | 1 | Clear, active low; ends and blocks pulses |
| lock_i | input | 1 | 1 = non-retriggerable, 0 = retriggerable |
| len_i | input | 16 | Pulse length in cycles (0 treated as 1) |
| q_o | output | 1 | Pulse output, high while active |
| qn_o | output | 1 | Inverse of `q_o` |

## Verification
Single isolated triggers on each input with several lengths, including 0, 1 and a long one, pin down latency, width and the zero-length rule. Wrong-qualifier edges separate correct gating from plain edge detection. A train of triggers spaced closer than the pulse length is run in both lock settings, which tells reloading apart from ignoring, and a length change during a pulse shows that the length is sampled only at the trigger. Clear is applied mid-pulse, held against trigger activity, and made to fall or rise in the same cycle as a trigger to expose the priority rule; a seeded random mix of all inputs is then compared cycle by cycle against the bench's own model.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;

  // Retrigger policy selected by the lock input.
  typedef enum logic {
    MODE_RETRIG = 1'b0,
    MODE_LOCK   = 1'b1
  } os_mode_e;

  // Qualified trigger events seen in one cycle.
  typedef struct packed {
    logic fall_hit;
    logic rise_hit;
  } os_hits_t;

endpackage

// File: rtl/os_sync.sv
module os_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [STAGES-1:0][W-1:0] pipe;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= '0;
        else        pipe <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= '0;
        else        pipe <= {pipe[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = pipe[STAGES-1];

endmodule

// File: rtl/os_edge_qual.sv
module os_edge_qual
  import oneshot_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     fall_lvl,
  input  logic     rise_lvl,
  input  logic     clr_lvl,
  output os_hits_t hits_o,
  output logic     accept_o
);

  logic fall_prev;
  logic rise_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fall_prev <= 1'b0;
      rise_prev <= 1'b0;
    end else begin
      fall_prev <= fall_lvl;
      rise_prev <= rise_lvl;
    end
  end

  // Each edge is qualified by the present level of the opposite input.
  always_comb begin
    hits_o.fall_hit = fall_prev & ~fall_lvl & rise_lvl;
    hits_o.rise_hit = rise_lvl & ~rise_prev & ~fall_lvl;
  end

  // Clear at its synchronised level blocks acceptance in the same cycle.
  assign accept_o = (hits_o.fall_hit | hits_o.rise_hit) & clr_lvl;

  // A level held steady yields at most one event.
  p_fall_once_r11: assert property (@(posedge clk) disable iff (!rst_n)
    hits_o.fall_hit |=> !hits_o.fall_hit);
  p_rise_once_r11: assert property (@(posedge clk) disable iff (!rst_n)
    hits_o.rise_hit |=> !hits_o.rise_hit);

endmodule

// File: rtl/os_pulse_core.sv
module os_pulse_core
  import oneshot_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_lvl,
  input  logic             accept,
  input  os_mode_e         mode,
  input  logic [LEN_W-1:0] len_i,
  output logic             active_o
);

  localparam logic [LEN_W-1:0] ZERO = '0;
  localparam logic [LEN_W-1:0] ONE  = {{(LEN_W-1){1'b0}}, 1'b1};

  // Cycles still to run after the load cycle; length 0 behaves as 1.
  function automatic logic [LEN_W-1:0] reload_of(input logic [LEN_W-1:0] len);
    return (len == ZERO) ? ZERO : len - ONE;
  endfunction

  logic             active;
  logic [LEN_W-1:0] remain;
  logic [LEN_W-1:0] load_val;
  logic             take;

  assign load_val = reload_of(len_i);
  assign take     = accept && (!active || mode == MODE_RETRIG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      remain <= ZERO;
    end else if (!clr_lvl) begin
      active <= 1'b0;
      remain <= ZERO;
    end else if (take) begin
      active <= 1'b1;
      remain <= load_val;
    end else if (active) begin
      if (remain == ZERO) active <= 1'b0;
      else                remain <= remain - ONE;
    end
  end

  assign active_o = active;

  p_clear_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_lvl |=> !active);
  p_idle_start_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_lvl && accept && !active) |=> active);
  p_retrig_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_lvl && accept && active && mode == MODE_RETRIG)
      |=> (active && remain == $past(load_val)));
  p_lock_ignores_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_lvl && active && mode == MODE_LOCK && remain != ZERO)
      |=> (active && remain == $past(remain) - ONE));
  p_expire_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_lvl && active && remain == ZERO && !take) |=> !active);

endmodule

// File: rtl/oneshot_timer.sv
module oneshot_timer
  import oneshot_pkg::*;
#(
  parameter int LEN_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_fall_i,
  input  logic             trig_rise_i,
  input  logic             clr_n_i,
  input  logic             lock_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             q_o,
  output logic             qn_o
);

  localparam int NSYNC = 3;

  logic [NSYNC-1:0] raw_lvls;
  logic [NSYNC-1:0] sync_lvls;
  os_hits_t         hits;
  logic             accept;
  logic             active;

  assign raw_lvls = {clr_n_i, trig_rise_i, trig_fall_i};

  os_sync #(.W(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (raw_lvls),
    .q_o   (sync_lvls)
  );

  os_edge_qual u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .fall_lvl (sync_lvls[0]),
    .rise_lvl (sync_lvls[1]),
    .clr_lvl  (sync_lvls[2]),
    .hits_o   (hits),
    .accept_o (accept)
  );

  os_pulse_core #(.LEN_W(LEN_W)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_lvl  (sync_lvls[2]),
    .accept   (accept),
    .mode     (os_mode_e'(lock_i)),
    .len_i    (len_i),
    .active_o (active)
  );

  assign q_o  = active;
  assign qn_o = ~active;

  // A held clear keeps the output low.
  p_no_spike_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_lvls[2] && !q_o) |=> !q_o);

endmodule

// File: tb/sim_oneshot_timer.sv
module sim_oneshot_timer;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        i0, i1, clr_n, lock;
  logic [15:0] len;
  logic        q, qn;

  int    checks = 0;
  int    errors = 0;
  string phase  = "R3";

  always #5 clk = ~clk;

  oneshot_timer u0 (
    .clk(clk), .rst_n(rst_n), .trig_fall_i(i0), .trig_rise_i(i1),
    .clr_n_i(clr_n), .lock_i(lock), .len_i(len), .q_o(q), .qn_o(qn)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_width(input int l);
    return (l == 0) ? 1 : l;
  endfunction

  function automatic int exp_train(input int n, input int gap, input int l, input bit lk);
    return lk ? exp_width(l) : (n - 1) * gap + exp_width(l);
  endfunction

  // Cycle model: two sync stages, one-cycle edge compare, then the pulse register.
  logic a1, a2, a3, b1, b2, b3, c1, c2, m_act;
  logic [15:0] m_rem;
  logic m_go;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {a1, a2, a3, b1, b2, b3, c1, c2, m_act} <= '0;
      m_rem <= '0;
    end else begin
      m_go = (((a3 & ~a2 & b2) | (b2 & ~b3 & ~a2)) & c2);
      a1 <= i0; a2 <= a1; a3 <= a2;
      b1 <= i1; b2 <= b1; b3 <= b2;
      c1 <= clr_n; c2 <= c1;
      if (!c2) begin
        m_act <= 1'b0; m_rem <= '0;
      end else if (m_go && (!m_act || !lock)) begin
        m_act <= 1'b1; m_rem <= (len == 0) ? 16'd0 : len - 16'd1;
      end else if (m_act) begin
        if (m_rem == 0) m_act <= 1'b0;
        else            m_rem <= m_rem - 16'd1;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(q === m_act, phase, int'(q), int'(m_act));
      chk(qn === ~q, "R3 complement", int'(qn), int'(~q));
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_width(output int lat, output int w);
    lat = 0;
    while (!q && lat < 40) begin @(negedge clk); lat++; end
    w = 0;
    while (q && w < 2000) begin w++; @(negedge clk); end
  endtask

  // Idle in fall mode: i0=1, i1=1. Fire a single falling edge on i0 and measure.
  task automatic single_fall(input int l, input string tag);
    int lat, w;
    len = 16'(l);
    i0 = 1'b0;
    run_width(lat, w);
    chk(lat == 3, "R11 latency", lat, 3);
    chk(w == exp_width(l), tag, w, exp_width(l));
    i0 = 1'b1;
    tick(4);
  endtask

  task automatic train(input int n, input int gap, input int l, input bit lk, input string tag);
    int lat, w;
    len = 16'(l); lock = lk;
    tick(1);
    fork
      begin
        for (int k = 0; k < n; k++) begin
          i0 = 1'b0; tick(1); i0 = 1'b1; tick(gap - 1);
        end
      end
      run_width(lat, w);
    join
    chk(w == exp_train(n, gap, l, lk), tag, w, exp_train(n, gap, l, lk));
    tick(4);
    lock = 1'b0;
  endtask

  initial begin
    int lat, w;
    rst_n = 1'b0; i0 = 1'b1; i1 = 1'b1; clr_n = 1'b1; lock = 1'b0; len = 16'd5;
    tick(3);
    chk(q == 1'b0, "R3 reset q", int'(q), 0);
    chk(qn == 1'b1, "R3 reset qn", int'(qn), 1);
    rst_n = 1'b1;
    tick(5);
    chk(q == 1'b0, "R3 idle after reset", int'(q), 0);

    phase = "R10";
    single_fall(5, "R1 width len5");
    single_fall(0, "R10 zero len");
    single_fall(1, "R10 len1");
    single_fall(7, "R12 back-to-back 1");
    single_fall(7, "R12 back-to-back 2");
    single_fall(300, "R10 long len");

    phase = "R10";
    len = 16'd8;
    fork
      begin i0 = 1'b0; tick(4); len = 16'd2; i0 = 1'b1; end
      run_width(lat, w);
    join
    chk(w == 8, "R10 len sampled at trigger", w, 8);
    tick(4);

    phase = "R4";
    train(5, 6, 10, 1'b0, "R4 retrigger extends");
    phase = "R5";
    train(3, 3, 10, 1'b1, "R5 lockout ignores");

    // R1 negative: i1 low disqualifies a fall on i0.
    phase = "R1";
    i1 = 1'b0; tick(4);
    i0 = 1'b0;
    for (int k = 0; k < 6; k++) begin tick(1); chk(q == 1'b0, "R1 disqualified", int'(q), 0); end

    // Rise mode: i0=0 already, i1=0. R2 positive.
    phase = "R2";
    len = 16'd4;
    i1 = 1'b1;
    run_width(lat, w);
    chk(lat == 3 && w == 4, "R2 rise triggers", w, 4);
    i1 = 1'b0; tick(3);
    // R2 negative: i0 high disqualifies.
    i0 = 1'b1; tick(4);
    i1 = 1'b1;
    for (int k = 0; k < 6; k++) begin tick(1); chk(q == 1'b0, "R2 disqualified", int'(q), 0); end
    tick(3);

    // R6: clear ends a pulse.
    phase = "R6";
    len = 16'd50;
    i0 = 1'b0; tick(10);
    chk(q == 1'b1, "R6 pulse running", int'(q), 1);
    clr_n = 1'b0; i0 = 1'b1;
    tick(2);
    chk(q == 1'b1, "R6 before clear lands", int'(q), 1);
    tick(1);
    chk(q == 1'b0, "R6 cleared", int'(q), 0);

    // R7: held clear blocks triggers.
    phase = "R7";
    for (int k = 0; k < 6; k++) begin
      i0 = ~i0; tick(1); chk(q == 1'b0, "R7 no spike", int'(q), 0);
      tick(1); chk(q == 1'b0, "R7 no spike", int'(q), 0);
    end
    i0 = 1'b1; tick(3);
    clr_n = 1'b1; tick(4);

    // R8: clear falls with trigger.
    phase = "R8";
    len = 16'd6;
    clr_n = 1'b0; i0 = 1'b0;
    for (int k = 0; k < 8; k++) begin tick(1); chk(q == 1'b0, "R8 clear wins", int'(q), 0); end
    i0 = 1'b1; tick(3);

    // R9: clear rises with trigger.
    phase = "R9";
    clr_n = 1'b1; i0 = 1'b0;
    run_width(lat, w);
    chk(lat == 3 && w == 6, "R9 trigger honoured", w, 6);
    i0 = 1'b1; tick(4);

    // Seeded random mix against the model.
    phase = "R11 random";
    void'($urandom(32'd2024));
    for (int k = 0; k < 4000; k++) begin
      if ($urandom % 4 == 0) i0 = ~i0;
      if ($urandom % 4 == 0) i1 = ~i1;
      if ($urandom % 16 == 0) clr_n = ~clr_n;
      if (!clr_n && $urandom % 3 == 0) clr_n = 1'b1;
      if ($urandom % 64 == 0) lock = ~lock;
      if ($urandom % 8 == 0) len = 16'($urandom % 12);
      tick(1);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule